// File: doc/BRIEF.md
# Block Address Permutation Engine

This block conceals the order in which a processor touches external memory. Every logical block address the processor emits is passed through an on-chip mapping table, and the physical address that results is what goes out to memory. The table is always a one-to-one map over the region. Because the table is held on chip, an observer of the address bus cannot tell which logical block is being accessed.

On request, the engine rebuilds the mapping and moves the stored data so that it matches the new mapping. The region is split into chunks, and each chunk is the size of an on-chip staging buffer. The chunks are handled one after another in ascending order. For each chunk, the engine first draws a fresh shuffle of the buffer slots. It does this with one Fisher-Yates swap per cycle, driven by a pseudo-random shift register. It then reads the chunk's blocks in ascending order and drops each block into the buffer slot that the shuffle selects. Finally, it writes the buffer back in ascending order.

While the reshuffle runs, translation is stalled. The new table replaces the old one in a single step, at the same moment as a one-cycle completion pulse. That pulse is intended to release the lock bits in the cache.

Top module: `perm_engine`

## Requirements
- R1: After reset, the map is the identity (`xl_phys` equals `xl_addr` for every address), `xl_ready` is 1, `perm_done` is 0 and `mem_req` is 0.
- R2: While idle, `xl_ready` is 1, and `xl_phys` shows the current map entry for `xl_addr` in the same cycle, with no register in the path.
- R3: From the cycle after `perm_req` is accepted until the completion pulse, `xl_ready` is 0. During that time, `xl_phys` for a held `xl_addr` does not change.
- R4: A chunk is the set of addresses that share the upper AW-BW bits. Chunk c holds addresses c*S to c*S+S-1, where S = 2^BW. For each chunk, in ascending order of c, the engine issues S reads (`mem_we`=0) at c*S+0 up to c*S+S-1, and then S writes (`mem_we`=1) at the same addresses in the same order. There are M/S passes in total and no other memory accesses.
- R5: Read data is taken from `mem_rdata` one cycle after the cycle in which the read request is asserted.
- R6: `perm_done` is high for exactly one cycle, the cycle after the last write. In that cycle, `xl_ready` is 1 and `xl_phys` already shows the new map.
- R7: The map is a bijection at all times: no two logical addresses translate to the same physical address.
- R8: After a reshuffle, the memory word at the new physical address of each logical block equals the word that was at its old physical address.
- R9: A reshuffle never moves a logical block out of its chunk: the upper AW-BW bits of its physical address stay the same.
- R10: A `perm_req` that arrives while a reshuffle is running is ignored. The access sequence of R4 continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_req | input | 1 | Start a reshuffle (taken when idle) |
| perm_done | output | 1 | One-cycle completion pulse |
| xl_addr | input | AW | Logical block address to translate |
| xl_phys | output | AW | Translated physical block address |
| xl_ready | output | 1 | Translation available (idle) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Physical block address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |

## Verification
Suppose a shuffle slot is duplicated or the buffer is scattered into the wrong slot. The translated table then loses its one-to-one property, or the data found through it stops matching the data stored before the reshuffle. Both faults show up as soon as the completion pulse arrives. A sequencing fault appears at the memory port in the very cycle of the misplaced access, because every access is compared in order against a precomputed list. A stall or commit fault appears as a change in `xl_phys` while the engine is busy, or as a wrong `xl_ready` or pulse width within one cycle.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SHUF,
    ST_LOAD,
    ST_WRITE
  } perm_state_e;
endpackage

// File: rtl/perm_lfsr.sv
module perm_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'h1D2B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] value
);
  logic [W-1:0] lfsr_q, lfsr_n;

  always_comb begin
    lfsr_n = lfsr_q;
    if (en) begin
      lfsr_n = lfsr_q >> 1;
      if (lfsr_q[0]) lfsr_n = lfsr_n ^ TAPS[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[W-1:0];
    else        lfsr_q <= lfsr_n;
  end

  assign value = lfsr_q;
endmodule

// File: rtl/perm_shuffle.sv
module perm_shuffle #(
  parameter int BW = 3,
  localparam int S = 1 << BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            swap_en,
  input  logic [BW-1:0]   k,
  input  logic [BW-1:0]   rnd,
  output logic [S*BW-1:0] sigma_flat
);
  logic [BW-1:0] sig_q [S];
  logic [BW-1:0] sig_n [S];
  logic [BW:0]   kp1;
  logic [2*BW:0] prod;
  logic [BW-1:0] j;

  // Scale rnd into [0, k] so the swap partner never exceeds k
  assign kp1  = {1'b0, k} + (BW+1)'(1);
  assign prod = (2*BW+1)'(rnd) * (2*BW+1)'(kp1);
  assign j    = prod[2*BW-1:BW];

  always_comb begin
    for (int i = 0; i < S; i++) sig_n[i] = sig_q[i];
    if (init) begin
      for (int i = 0; i < S; i++) sig_n[i] = BW'(i);
    end else if (swap_en) begin
      sig_n[k] = sig_q[j];
      sig_n[j] = sig_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) sig_q[i] <= BW'(i);
    end else begin
      for (int i = 0; i < S; i++) sig_q[i] <= sig_n[i];
    end
  end

  for (genvar g = 0; g < S; g++) begin : g_flat
    assign sigma_flat[g*BW +: BW] = sig_q[g];
  end

  logic [S-1:0] slot_seen;
  always_comb begin
    slot_seen = '0;
    for (int i = 0; i < S; i++) slot_seen[sig_q[i]] = 1'b1;
  end

  // R7: the slot shuffle stays a permutation after every swap
  assert_sigma_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_seen) == S);
endmodule

// File: rtl/perm_map.sv
module perm_map #(
  parameter int AW = 6,
  parameter int BW = 3,
  localparam int M  = 1 << AW,
  localparam int S  = 1 << BW,
  localparam int CW = AW - BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            upd,
  input  logic            commit,
  input  logic [CW-1:0]   chunk,
  input  logic [S*BW-1:0] sigma_flat,
  input  logic [AW-1:0]   xl_addr,
  output logic [AW-1:0]   xl_phys
);
  logic [AW-1:0] cur_q [M];
  logic [AW-1:0] nxt_q [M];
  logic [AW-1:0] cur_n [M];
  logic [AW-1:0] nxt_n [M];

  always_comb begin
    for (int l = 0; l < M; l++) begin
      cur_n[l] = cur_q[l];
      nxt_n[l] = nxt_q[l];
      if (start) nxt_n[l] = cur_q[l];
      if (upd && cur_q[l][AW-1:BW] == chunk)
        nxt_n[l] = {chunk, sigma_flat[cur_q[l][BW-1:0]*BW +: BW]};
      if (commit) cur_n[l] = nxt_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < M; l++) begin
        cur_q[l] <= AW'(l);
        nxt_q[l] <= AW'(l);
      end
    end else begin
      for (int l = 0; l < M; l++) begin
        cur_q[l] <= cur_n[l];
        nxt_q[l] <= nxt_n[l];
      end
    end
  end

  assign xl_phys = cur_q[xl_addr];

  for (genvar g = 0; g < M; g++) begin : g_chk
    // R9: a commit keeps each block inside its chunk
    assert_chunk_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> cur_q[g][AW-1:BW] == $past(cur_q[g][AW-1:BW]));
    // R3: the live map changes only on commit
    assert_map_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> cur_q[g] == $past(cur_q[g]));
  end
endmodule

// File: rtl/perm_engine.sv
module perm_engine #(
  parameter int          AW   = 6,
  parameter int          BW   = 3,
  parameter int          DW   = 16,
  parameter logic [15:0] SEED = 16'h1D2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          perm_req,
  output logic          perm_done,
  input  logic [AW-1:0] xl_addr,
  output logic [AW-1:0] xl_phys,
  output logic          xl_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import perm_pkg::*;

  localparam int S  = 1 << BW;
  localparam int CW = AW - BW;

  perm_state_e   state_q, state_n;
  logic [BW:0]   cnt_q, cnt_n;
  logic [CW-1:0] chunk_q, chunk_n;
  logic          done_q, done_n;
  logic          cap_vld_q, cap_vld_n;
  logic [BW-1:0] cap_idx_q, cap_idx_n;
  logic          map_start, map_upd, map_commit, shuf_init, shuf_swap;
  logic [15:0]   rnd;
  logic [S*BW-1:0] sigma_flat;
  logic [DW-1:0] buf_q [S];

  perm_lfsr #(.W(16), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .en(shuf_swap), .value(rnd)
  );

  perm_shuffle #(.BW(BW)) u_shuf (
    .clk(clk), .rst_n(rst_n), .init(shuf_init), .swap_en(shuf_swap),
    .k(cnt_q[BW-1:0]), .rnd(rnd[BW-1:0]), .sigma_flat(sigma_flat)
  );

  perm_map #(.AW(AW), .BW(BW)) u_map (
    .clk(clk), .rst_n(rst_n), .start(map_start), .upd(map_upd),
    .commit(map_commit), .chunk(chunk_q), .sigma_flat(sigma_flat),
    .xl_addr(xl_addr), .xl_phys(xl_phys)
  );

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    chunk_n    = chunk_q;
    done_n     = 1'b0;
    cap_vld_n  = 1'b0;
    cap_idx_n  = cap_idx_q;
    map_start  = 1'b0;
    map_upd    = 1'b0;
    map_commit = 1'b0;
    shuf_init  = 1'b0;
    shuf_swap  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = {chunk_q, cnt_q[BW-1:0]};
    unique case (state_q)
      ST_IDLE: if (perm_req) begin
        map_start = 1'b1;
        chunk_n   = '0;
        state_n   = ST_INIT;
      end
      ST_INIT: begin
        shuf_init = 1'b1;
        cnt_n     = (BW+1)'(S-1);
        state_n   = ST_SHUF;
      end
      ST_SHUF: begin
        shuf_swap = 1'b1;
        if (cnt_q == (BW+1)'(1)) begin
          cnt_n   = '0;
          state_n = ST_LOAD;
        end else begin
          cnt_n = cnt_q - (BW+1)'(1);
        end
      end
      ST_LOAD: begin
        map_upd = (cnt_q == '0);
        if (cnt_q != (BW+1)'(S)) begin
          mem_req   = 1'b1;
          cap_vld_n = 1'b1;
          cap_idx_n = cnt_q[BW-1:0];
          cnt_n     = cnt_q + (BW+1)'(1);
        end else begin
          cnt_n   = '0;
          state_n = ST_WRITE;
        end
      end
      ST_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (cnt_q == (BW+1)'(S-1)) begin
          cnt_n = '0;
          if (chunk_q == {CW{1'b1}}) begin
            map_commit = 1'b1;
            done_n     = 1'b1;
            state_n    = ST_IDLE;
          end else begin
            chunk_n = chunk_q + CW'(1);
            state_n = ST_INIT;
          end
        end else begin
          cnt_n = cnt_q + (BW+1)'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      chunk_q   <= '0;
      done_q    <= 1'b0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      chunk_q   <= chunk_n;
      done_q    <= done_n;
      cap_vld_q <= cap_vld_n;
      cap_idx_q <= cap_idx_n;
    end
  end

  // Staging buffer: datapath storage, written only on capture
  always_ff @(posedge clk) begin
    if (cap_vld_q) buf_q[sigma_flat[cap_idx_q*BW +: BW]] <= mem_rdata;
  end

  assign mem_wdata = buf_q[cnt_q[BW-1:0]];
  assign xl_ready  = (state_q == ST_IDLE);
  assign perm_done = done_q;

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_done |=> !perm_done);
  // R4: back-to-back reads walk upward by one block
  assert_rd_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we))
      |-> mem_addr == $past(mem_addr) + AW'(1));
  // R4: back-to-back writes walk upward by one block
  assert_wr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we))
      |-> mem_addr == $past(mem_addr) + AW'(1));
  // R3: no translation offered while memory is being reshuffled
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !xl_ready);
endmodule

// File: tb/perm_engine_tb.sv
module perm_engine_tb_top;
  localparam int AW = 6;
  localparam int BW = 3;
  localparam int DW = 16;
  localparam int M  = 1 << AW;
  localparam int S  = 1 << BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          perm_req;
  logic          perm_done;
  logic [AW-1:0] xl_addr;
  logic [AW-1:0] xl_phys;
  logic          xl_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] rd_q;

  logic [DW-1:0] mem [M];
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  perm_engine #(.AW(AW), .BW(BW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .perm_req(perm_req), .perm_done(perm_done),
    .xl_addr(xl_addr), .xl_phys(xl_phys), .xl_ready(xl_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rd_q)
  );

  // Behavioural external memory: one-cycle read latency (R5)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < M; i++) mem[i] <= DW'(16'hA500 + i * 37);
      rd_q <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        rd_q <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int old_map [M];
    int new_map [M];
    logic [DW-1:0] old_data [M];
    int q [$];
    int probe;
    int probe_after;
    int cyc;
    bit got_done;
    bit [M-1:0] seen;
    int changed;

    rst_n    = 1'b0;
    perm_req = 1'b0;
    xl_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(xl_ready == 1'b1, "R1 ready", int'(xl_ready), 1);
    chk(perm_done == 1'b0, "R1 done", int'(perm_done), 0);
    chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
    for (int l = 0; l < M; l++) begin
      xl_addr = AW'(l);
      #0.1;
      chk(int'(xl_phys) == l, "R1 identity", int'(xl_phys), l);
    end
    @(negedge clk);

    changed = 0;
    for (int round = 0; round < 3; round++) begin
      // R2: snapshot of the current map read combinationally while idle
      for (int l = 0; l < M; l++) begin
        xl_addr = AW'(l);
        #0.1;
        old_map[l] = int'(xl_phys);
        old_data[l] = mem[xl_phys];
      end
      chk(xl_ready == 1'b1, "R2 ready idle", int'(xl_ready), 1);
      probe = 5 + round * 17;
      xl_addr = AW'(probe);
      #0.1;
      chk(int'(xl_phys) == old_map[probe], "R2 translate", int'(xl_phys), old_map[probe]);

      q.delete();
      for (int c = 0; c < M / S; c++) begin
        for (int i = 0; i < S; i++) q.push_back(c * S + i);
        for (int i = 0; i < S; i++) q.push_back(256 + c * S + i);
      end

      @(negedge clk);
      perm_req = 1'b1;
      @(negedge clk);
      perm_req = 1'b0;
      cyc = 0;
      got_done = 1'b0;
      while (!got_done && cyc < 5000) begin
        if (perm_done) begin
          got_done = 1'b1;
        end else begin
          chk(xl_ready == 1'b0, "R3 stall", int'(xl_ready), 0);
          chk(int'(xl_phys) == old_map[probe], "R3 frozen map", int'(xl_phys), old_map[probe]);
          if (mem_req) begin
            if (q.size() == 0) begin
              chk(1'b0, "R4 extra access", int'(mem_addr), -1);
            end else begin
              int e;
              e = q.pop_front();
              chk((int'(mem_we) * 256 + int'(mem_addr)) == e, "R4 R10 access order",
                  int'(mem_we) * 256 + int'(mem_addr), e);
            end
          end
          // R10: a second request mid-run must not restart anything
          if (cyc == 6 || cyc == 60) perm_req = 1'b1;
          else                       perm_req = 1'b0;
          @(negedge clk);
          cyc++;
        end
      end
      perm_req = 1'b0;
      chk(got_done, "R6 done seen", int'(got_done), 1);
      chk(q.size() == 0, "R4 all passes issued", q.size(), 0);
      chk(xl_ready == 1'b1, "R6 ready at done", int'(xl_ready), 1);
      chk(mem_req == 1'b0, "R6 no access at done", int'(mem_req), 0);
      probe_after = int'(xl_phys);
      @(negedge clk);
      chk(perm_done == 1'b0, "R6 pulse width", int'(perm_done), 0);

      // Full table after the swap
      seen = '0;
      for (int l = 0; l < M; l++) begin
        xl_addr = AW'(l);
        #0.1;
        new_map[l] = int'(xl_phys);
        seen[xl_phys] = 1'b1;
        if (new_map[l] != old_map[l]) changed++;
        chk((new_map[l] / S) == (old_map[l] / S), "R9 chunk kept", new_map[l] / S, old_map[l] / S);
        chk(mem[xl_phys] == old_data[l], "R8 R5 data follows block", int'(mem[xl_phys]), int'(old_data[l]));
      end
      chk(seen == '1, "R7 bijection", $countones(seen), M);
      chk(probe_after == new_map[probe], "R6 new map at done", probe_after, new_map[probe]);
      @(negedge clk);
    end
    chk(changed > 0, "R8 map moved", changed, 1);
    finish_run();
  end
endmodule